// File: doc/BRIEF.md
# Key-Protected Erase Sequencer for Data Nonvolatile Memory

This block sits on a processor's register bus and starts erase cycles on a small data nonvolatile array. Software sets a target address in an upper and a lower address register and picks word or block mode in a control register. It then writes a two-byte unlock key and sets the start bit. The erase runs in the background for a fixed number of clock cycles. The bus stays fully usable during that time.

When the cycle ends, the block sends a one-cycle erase strobe with a word/block select and the address to the array model. It clears the start bit and the write-enable bit in hardware. It also raises a sticky completion flag, which drives an interrupt line. A start attempt without a fresh, unbroken unlock sequence, or with an unusable configuration, is refused and sets a sticky error bit.

Register selects: 0 = control, 1 = lower address, 2 = upper address, 3 = key. Control bits: 15 start/busy, 14 write enable, 13 error (write 1 to clear), 12 done (write 1 to clear), 6 erase, 3:0 mode (0x5 block, 0x4 word). All other control bits read 0.

Top module: `nvm_erase_ctrl`

## Requirements
- R1: After synchronous reset, the control and address registers read 0, and `busy`, `irq_done` and `erase_stb` are 0.
- R2: The lower address register holds 16 bits. The upper address register holds its low 8 bits, and its upper bits read 0. `erase_addr` is {upper[7:0], lower}.
- R3: Writing 0x55 and then 0xAA to the key register, followed at once by a control write with bits 15, 14 and 6 set and mode 0x5 or 0x4, starts an erase. `busy` and control bit 15 read 1 from the next cycle.
- R4: A start is refused and error bit 13 is set if any other write comes between 0x55 and 0xAA or between 0xAA and the start write, or if the keys come in the wrong order. A refused start leaves `busy` at 0 and leaves the other control fields unchanged.
- R5: A start is refused and bit 13 is set when the start write has bit 14 or bit 6 clear, or a mode other than 0x5 or 0x4. A control write with bit 15 clear loads bits 14, 6 and 3:0.
- R6: `busy` stays high for exactly ERASE_CYCLES clock cycles. Register reads keep working during that time.
- R7: In the cycle after `busy` falls, `erase_stb` is high for exactly one cycle. At that point `erase_blk` is 1 for mode 0x5 and 0 for mode 0x4, `erase_addr` is valid, and control bits 15 and 14 read 0.
- R8: At completion, done bit 12 and `irq_done` become 1. They stay 1 until a control write with bit 12 set while idle. Writing bit 13 set clears the error bit.
- R9: While `busy` is high, including its final cycle, writes to the control and address registers are ignored. A clear of the done flag that lands on the completing edge is lost, and the flag ends up set.
- R10: The key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| busy | output | 1 | Erase in progress |
| irq_done | output | 1 | Sticky completion interrupt |
| erase_stb | output | 1 | One-cycle erase command to the array |
| erase_blk | output | 1 | 1 = block erase, 0 = word erase |
| erase_addr | output | 24 | Erase target address |

## Verification
Two things can fall on the same clock edge: the erase timer reaching its end, which sets the done flag and clears write-enable, and a software control write that tries to clear the done flag. The bench places a write-1-to-clear of bit 12 so that it lands on the last edge of the busy window. It then checks that `busy` has fallen and that the done flag and `irq_done` are still set. It also checks that a later idle clear takes effect.

// File: rtl/nvm_erase_pkg.sv
package nvm_erase_pkg;

    localparam int DATA_W  = 16;
    localparam int AHI_W   = 8;
    localparam int ADDR_W  = AHI_W + DATA_W;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ALO  = 2'd1,
        SEL_AHI  = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int B_START = 15;
    localparam int B_WEN   = 14;
    localparam int B_ERR   = 13;
    localparam int B_DONE  = 12;
    localparam int B_ERASE = 6;

    localparam logic [3:0] MODE_BLOCK = 4'h5;
    localparam logic [3:0] MODE_WORD  = 4'h4;

    typedef enum logic [1:0] {
        UNL_IDLE  = 2'd0,
        UNL_HALF  = 2'd1,
        UNL_ARMED = 2'd2
    } unlock_e;

    typedef struct packed {
        logic       wen;
        logic       erase;
        logic [3:0] mode;
        logic       err;
        logic       done;
    } ctrl_t;

    function automatic logic cfg_ok(input logic [DATA_W-1:0] w);
        return w[B_WEN] && w[B_ERASE] &&
               ((w[3:0] == MODE_BLOCK) || (w[3:0] == MODE_WORD));
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input logic busy, input ctrl_t c);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[B_START] = busy;
        v[B_WEN]   = c.wen;
        v[B_ERR]   = c.err;
        v[B_DONE]  = c.done;
        v[B_ERASE] = c.erase;
        v[3:0]     = c.mode;
        return v;
    endfunction

endpackage

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
    import nvm_erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              armed
);

    unlock_e state_q, state_d;
    logic    key_wr;

    assign key_wr = bus_we && (bus_sel == SEL_KEY);

    always_comb begin
        state_d = state_q;
        if (bus_we) begin
            if (key_wr && bus_wdata[7:0] == KEY_FIRST && bus_wdata[DATA_W-1:8] == '0)
                state_d = UNL_HALF;
            else if (key_wr && state_q == UNL_HALF &&
                     bus_wdata[7:0] == KEY_SECOND && bus_wdata[DATA_W-1:8] == '0)
                state_d = UNL_ARMED;
            else
                state_d = UNL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= UNL_IDLE;
        else     state_q <= state_d;
    end

    assign armed = (state_q == UNL_ARMED);

    AST_ARM_AFTER_SECOND_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(key_wr && bus_wdata[7:0] == KEY_SECOND)) else $error("arm"); // R4

    AST_ARM_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        armed && bus_we |=> !armed) else $error("arm drop"); // R4

endmodule

// File: rtl/nvm_erase_timer.sv
module nvm_erase_timer #(
    parameter int ERASE_CYCLES = 80000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic last,
    output logic stb
);

    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             stb_q;

    assign last = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= last;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
            end else if (last) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign stb  = stb_q;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb) else $error("stb width"); // R7

    AST_STB_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> stb) else $error("stb place"); // R6

endmodule

// File: rtl/nvm_erase_regs.sv
module nvm_erase_regs
    import nvm_erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              armed,
    input  logic              busy,
    input  logic              last,
    output logic              start,
    output logic              blk,
    output logic              done,
    output logic [ADDR_W-1:0] addr
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] alo_q;
    logic [AHI_W-1:0]  ahi_q;
    logic              ctrl_wr;
    logic              idle_ctrl_wr;

    assign ctrl_wr      = bus_we && (bus_sel == SEL_CTRL);
    assign idle_ctrl_wr = ctrl_wr && !busy;
    assign start        = idle_ctrl_wr && bus_wdata[B_START] && armed && cfg_ok(bus_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (last) begin
            ctrl_q.wen  <= 1'b0;
            ctrl_q.done <= 1'b1;
        end else if (idle_ctrl_wr) begin
            if (bus_wdata[B_START]) begin
                if (start) begin
                    ctrl_q.wen   <= bus_wdata[B_WEN];
                    ctrl_q.erase <= bus_wdata[B_ERASE];
                    ctrl_q.mode  <= bus_wdata[3:0];
                end else begin
                    ctrl_q.err <= 1'b1;
                end
            end else begin
                ctrl_q.wen   <= bus_wdata[B_WEN];
                ctrl_q.erase <= bus_wdata[B_ERASE];
                ctrl_q.mode  <= bus_wdata[3:0];
                if (bus_wdata[B_ERR])  ctrl_q.err  <= 1'b0;
                if (bus_wdata[B_DONE]) ctrl_q.done <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alo_q <= '0;
            ahi_q <= '0;
        end else if (bus_we && !busy) begin
            if (bus_sel == SEL_ALO) alo_q <= bus_wdata;
            if (bus_sel == SEL_AHI) ahi_q <= bus_wdata[AHI_W-1:0];
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_sel))
            SEL_CTRL: bus_rdata = ctrl_pack(busy, ctrl_q);
            SEL_ALO:  bus_rdata = alo_q;
            SEL_AHI:  bus_rdata = {{(DATA_W-AHI_W){1'b0}}, ahi_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign blk  = (ctrl_q.mode == MODE_BLOCK);
    assign done = ctrl_q.done;
    assign addr = {ahi_q, alo_q};

    AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(armed)) else $error("unkeyed start"); // R3

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(alo_q) && $stable(ahi_q) && $stable(ctrl_q.mode)) else $error("addr moved"); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.done && !(idle_ctrl_wr && !bus_wdata[B_START] && bus_wdata[B_DONE])
        |=> ctrl_q.done) else $error("done lost"); // R8

    AST_WEN_OFF_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !ctrl_q.wen && ctrl_q.done) else $error("wen"); // R7

endmodule

// File: rtl/nvm_erase_ctrl.sv
module nvm_erase_ctrl
    import nvm_erase_pkg::*;
#(
    parameter int ERASE_CYCLES = 80000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              irq_done,
    output logic              erase_stb,
    output logic              erase_blk,
    output logic [ADDR_W-1:0] erase_addr
);

    logic armed;
    logic start;
    logic last;

    nvm_unlock_seq u_unlock (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    nvm_erase_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .armed     (armed),
        .busy      (busy),
        .last      (last),
        .start     (start),
        .blk       (erase_blk),
        .done      (irq_done),
        .addr      (erase_addr)
    );

    nvm_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .last  (last),
        .stb   (erase_stb)
    );

endmodule

// File: tb/nvm_erase_ctrl_test.sv
module nvm_erase_ctrl_test;

    localparam int N = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        busy, irq_done, erase_stb, erase_blk;
    logic [23:0] erase_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nvm_erase_ctrl #(.ERASE_CYCLES(N)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .irq_done(irq_done), .erase_stb(erase_stb), .erase_blk(erase_blk),
        .erase_addr(erase_addr)
    );

    always @(negedge clk) if (busy) cyc++;

    localparam logic [33:0] VEC [6] = '{
        {2'd1, 16'h1234, 16'h1234},
        {2'd2, 16'hFFAB, 16'h00AB},
        {2'd3, 16'h0055, 16'h0000},
        {2'd1, 16'hBEEF, 16'hBEEF},
        {2'd2, 16'h0012, 16'h0012},
        {2'd1, 16'h0100, 16'h0100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic keys();
        wr(2'd3, 16'h0055);
        wr(2'd3, 16'h00AA);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, r); chk("R1 ctrl", r, 0);
        rd(2'd1, r); chk("R1 alo", r, 0);
        rd(2'd2, r); chk("R1 ahi", r, 0);
        chk("R1 outs", {busy, irq_done, erase_stb}, 0);

        // R2 / R10 vector walk
        foreach (VEC[i]) begin
            wr(VEC[i][33:32], VEC[i][31:16]);
            rd(VEC[i][33:32], r);
            chk(VEC[i][33:32] == 2'd3 ? "R10 key read" : "R2 addr read", r, VEC[i][15:0]);
        end
        chk("R2 erase_addr", erase_addr, 24'h120100);

        // R3/R6/R7/R8/R9 block erase
        wr(2'd0, 16'h4045);
        rd(2'd0, r); chk("R5 cfg load", r, 16'h4045);
        keys();
        cyc = 0;
        wr(2'd0, 16'hC045);
        chk("R3 busy", busy, 1);
        rd(2'd0, r); chk("R3 start bit", r[15], 1);
        rd(2'd1, r); chk("R6 read while busy", r, 16'h0100);
        wr(2'd1, 16'h7777);
        wr(2'd0, 16'h0000);
        rd(2'd1, r); chk("R9 addr ignored", r, 16'h0100);
        rd(2'd0, r); chk("R9 ctrl ignored", r, 16'hC045);
        wait_idle();
        chk("R6 busy length", cyc, N);
        chk("R7 strobe", erase_stb, 1);
        chk("R7 block sel", erase_blk, 1);
        chk("R7 addr", erase_addr, 24'h120100);
        rd(2'd0, r); chk("R7 ctrl after end", r, 16'h1045);
        chk("R8 irq", irq_done, 1);
        @(negedge clk);
        chk("R7 strobe one cycle", erase_stb, 0);
        repeat (3) @(negedge clk);
        chk("R8 irq sticky", irq_done, 1);
        wr(2'd0, 16'h1000);
        chk("R8 irq cleared", irq_done, 0);
        rd(2'd0, r); chk("R8 ctrl cleared", r, 16'h0000);

        // word erase
        wr(2'd0, 16'h4044);
        keys();
        wr(2'd0, 16'hC044);
        chk("R3 word start", busy, 1);
        wait_idle();
        chk("R7 word strobe", erase_stb, 1);
        chk("R7 word sel", erase_blk, 0);
        wr(2'd0, 16'h1000);

        // R4 broken sequence
        wr(2'd0, 16'h4045);
        wr(2'd3, 16'h0055);
        wr(2'd1, 16'h0200);
        wr(2'd3, 16'h00AA);
        wr(2'd0, 16'hC045);
        chk("R4 broken no busy", busy, 0);
        rd(2'd0, r); chk("R4 broken err", r, 16'h6045);
        wr(2'd0, 16'h2000);
        rd(2'd0, r); chk("R8 err clear", r, 16'h0000);

        // R4 wrong order
        wr(2'd0, 16'h4045);
        wr(2'd3, 16'h00AA);
        wr(2'd3, 16'h0055);
        wr(2'd0, 16'hC045);
        chk("R4 order no busy", busy, 0);
        rd(2'd0, r); chk("R4 order err", r[13], 1);
        wr(2'd0, 16'h2000);

        // R5 missing enable
        wr(2'd0, 16'h0045);
        keys();
        wr(2'd0, 16'h8045);
        chk("R5 no wen busy", busy, 0);
        rd(2'd0, r); chk("R5 no wen err", r, 16'h2045);
        wr(2'd0, 16'h2000);

        // R5 bad mode
        keys();
        wr(2'd0, 16'hC047);
        chk("R5 bad mode busy", busy, 0);
        rd(2'd0, r); chk("R5 bad mode err", r[13], 1);
        wr(2'd0, 16'h2000);

        // R9 collision: flag clear lands on completing edge
        wr(2'd0, 16'h4045);
        keys();
        wr(2'd0, 16'hC045);
        repeat (N - 1) @(negedge clk);
        chk("R9 still busy before end", busy, 1);
        wr(2'd0, 16'h1000);
        chk("R9 busy fell", busy, 0);
        chk("R9 done wins", irq_done, 1);
        rd(2'd0, r); chk("R9 ctrl after collision", r, 16'h1045);
        wr(2'd0, 16'h1000);
        chk("R8 later clear", irq_done, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule